// File: doc/BRIEF.md
# Ring-Oscillator Array Controller

This block is the clocked logic that sits around an array of cross-coupled ring-oscillator entropy cells. The oscillators are not part of it. It takes the raw output of every cell, passes the last cell's output through a two-flop synchronizer, and hands the second flop downstream as the random bit. It also produces each cell's long/short path select line from a neighbouring cell's output.

The first synchronizer flop sets the coupling direction. When it is 0, each cell drives the select of the cell after it. When it is 1, each cell drives the select of the cell before it. Both directions wrap around the end of the array. Because the first flop changes with the raw entropy, the direction can change on any cycle.

The unit enable is also the only reset. While it is low, the synchronizer and every latch-enable flop are cleared, so every inverting latch is held in reset. While it is high, a long chain with one flop per latch fills with ones from its low end and releases the latches one at a time. When the top flop of the chain is set, the sampling unit is enabled.

Top module: `ro_array_ctrl`

## Requirements
- R1: On every clock edge with the enable low, all latch enables, the random bit and the sampler enable become 0.
- R2: While the enable stays high, the random bit equals the last cell's output sampled two edges earlier.
- R3: When the last cell's output captured at the previous edge is 0 (forward coupling), the select of cell (i+1) mod N equals the output of cell i. So cell N-1 drives cell 0.
- R4: When the last cell's output captured at the previous edge is 1 (reverse coupling), the select of cell i equals the output of cell (i+1) mod N. So cell 0 drives cell N-1.
- R5: After k consecutive enabled edges, exactly the k lowest latch-enable bits are 1 (bit 0 first). The chain stops filling when it is full.
- R6: Cell i owns 2*(START+i*INC)+DELAY consecutive latch-enable bits, placed after the bits of the cells before it. The defaults give 8+12+16 = 36 bits in total.
- R7: The sampler enable is 1 exactly when the top latch-enable bit is 1. With the defaults, this first happens on the 36th enabled edge.
- R8: Dropping the enable part-way through the fill clears the chain. After the enable returns, the fill restarts from bit 0, the first enabled edge gives a random bit of 0, and coupling in that cycle is forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also samples the entropy |
| enableIn | input | 1 | Unit enable; low clears all state |
| cellOut | input | NUM_CELLS | Raw output of each entropy cell |
| latchEn | output | TOTAL | One enable per inverting latch, bit 0 released first |
| pathSel | output | NUM_CELLS | Per-cell select: long or short path |
| randBit | output | 1 | Synchronized random bit |
| samplerEn | output | 1 | Enables the downstream sampling unit |

## Verification
The bench builds the block with the default parameters: three cells with START=3, INC=2 and DELAY=2. This gives segments of 8, 12 and 16 flops, so the full chain of 36 takes only a few dozen cycles to fill. That short fill puts the sampler-enable edge, a fill aborted in the middle and a restart all within a short run. The bench stands in for the oscillators by driving the cell outputs from seeded random values mixed with fixed patterns. It therefore exercises both coupling directions, including the wrap-around neighbour at each end.

// File: rtl/roac_pkg.sv
package roac_pkg;

  // Strobes from the fill control to the synchronizer/coupling datapath
  typedef struct packed {
    logic clear;    // unit disabled: hold everything in reset
    logic run;      // unit enabled: advance state
  } roacStrobes_t;

  // number of latch-enable flops owned by cell idx (short chain + long chain)
  function automatic int segLen(int start, int inc, int delay, int idx);
    return 2 * (start + idx * inc) + delay;
  endfunction

  // first latch-enable bit owned by cell idx
  function automatic int segBase(int start, int inc, int delay, int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += segLen(start, inc, delay, k);
    return acc;
  endfunction

endpackage

// File: rtl/roac_fill_ctrl.sv
module roac_fill_ctrl
  import roac_pkg::*;
#(
  parameter int NUM_CELLS = 3,
  parameter int INV_START = 3,
  parameter int INV_INC   = 2,
  parameter int INV_DELAY = 2,
  localparam int TOTAL    = segBase(INV_START, INV_INC, INV_DELAY, NUM_CELLS)
) (
  input  logic             clk,
  input  logic             enableIn,
  output logic [TOTAL-1:0] latchEn,
  output logic             samplerEn,
  output roacStrobes_t     strobes
);

  // link[i] feeds the low end of cell i's segment; link[NUM_CELLS] is the chain top
  logic [NUM_CELLS:0] link;
  assign link[0] = 1'b1;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : gCell
    localparam int LEN  = segLen(INV_START, INV_INC, INV_DELAY, i);
    localparam int BASE = segBase(INV_START, INV_INC, INV_DELAY, i);
    logic [LEN-1:0] seg;

    always_ff @(posedge clk) begin
      if (!enableIn) seg <= '0;
      else           seg <= {seg[LEN-2:0], link[i]};
    end

    assign link[i+1]              = seg[LEN-1];
    assign latchEn[BASE +: LEN]   = seg;
  end

  assign samplerEn     = link[NUM_CELLS];
  assign strobes.clear = ~enableIn;
  assign strobes.run   = enableIn;

endmodule

// File: rtl/roac_couple_dp.sv
module roac_couple_dp
  import roac_pkg::*;
#(
  parameter int NUM_CELLS = 3
) (
  input  logic                 clk,
  input  roacStrobes_t         strobes,
  input  logic [NUM_CELLS-1:0] cellOut,
  output logic [NUM_CELLS-1:0] pathSel,
  output logic                 randBit
);

  logic syncFirst, syncSecond;

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      syncFirst  <= 1'b0;
      syncSecond <= 1'b0;
    end else if (strobes.run) begin
      syncFirst  <= cellOut[NUM_CELLS-1];
      syncSecond <= syncFirst;
    end
  end

  assign randBit = syncSecond;

  // direction: syncFirst=0 -> previous cell drives, syncFirst=1 -> next cell drives
  for (genvar i = 0; i < NUM_CELLS; i++) begin : gSel
    localparam int PREV = (i + NUM_CELLS - 1) % NUM_CELLS;
    localparam int NEXT = (i + 1) % NUM_CELLS;
    assign pathSel[i] = syncFirst ? cellOut[NEXT] : cellOut[PREV];
  end

endmodule

// File: rtl/ro_array_ctrl.sv
module ro_array_ctrl
  import roac_pkg::*;
#(
  parameter int NUM_CELLS = 3,
  parameter int INV_START = 3,
  parameter int INV_INC   = 2,
  parameter int INV_DELAY = 2,
  localparam int TOTAL    = segBase(INV_START, INV_INC, INV_DELAY, NUM_CELLS)
) (
  input  logic                 clk,
  input  logic                 enableIn,
  input  logic [NUM_CELLS-1:0] cellOut,
  output logic [TOTAL-1:0]     latchEn,
  output logic [NUM_CELLS-1:0] pathSel,
  output logic                 randBit,
  output logic                 samplerEn
);

  roacStrobes_t strobes;

  roac_fill_ctrl #(
    .NUM_CELLS(NUM_CELLS), .INV_START(INV_START),
    .INV_INC(INV_INC), .INV_DELAY(INV_DELAY)
  ) u_ctrl (
    .clk(clk), .enableIn(enableIn), .latchEn(latchEn),
    .samplerEn(samplerEn), .strobes(strobes)
  );

  roac_couple_dp #(.NUM_CELLS(NUM_CELLS)) u_dp (
    .clk(clk), .strobes(strobes), .cellOut(cellOut),
    .pathSel(pathSel), .randBit(randBit)
  );

endmodule

// File: rtl/roac_checker.sv
module roac_checker #(
  parameter int NUM_CELLS = 3,
  parameter int TOTAL     = 36
) (
  input logic                 clk,
  input logic                 enableIn,
  input logic [NUM_CELLS-1:0] cellOut,
  input logic [TOTAL-1:0]     latchEn,
  input logic [NUM_CELLS-1:0] pathSel,
  input logic                 randBit,
  input logic                 samplerEn
);

  a_r1_disabled_clear: assert property (@(posedge clk)
    !enableIn |=> (latchEn == '0 && !randBit && !samplerEn));

  a_r2_sync_delay: assert property (@(posedge clk) disable iff (!enableIn)
    enableIn && $past(enableIn) |=> randBit == $past(cellOut[NUM_CELLS-1], 2));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : gCouple
    a_r3_forward: assert property (@(posedge clk) disable iff (!enableIn)
      $past(enableIn) && !$past(cellOut[NUM_CELLS-1])
        |-> pathSel[(i+1) % NUM_CELLS] == cellOut[i]);
    a_r4_reverse: assert property (@(posedge clk) disable iff (!enableIn)
      $past(enableIn) && $past(cellOut[NUM_CELLS-1])
        |-> pathSel[i] == cellOut[(i+1) % NUM_CELLS]);
  end

  a_r5_thermometer: assert property (@(posedge clk) disable iff (!enableIn)
    enableIn |=> latchEn[0] &&
      ((latchEn & (latchEn + {{(TOTAL-1){1'b0}}, 1'b1})) == '0));

  a_r5_one_per_edge: assert property (@(posedge clk) disable iff (!enableIn)
    enableIn && !samplerEn |=> $countones(latchEn) == $countones($past(latchEn)) + 1);

  a_r7_sampler_full: assert property (@(posedge clk) disable iff (!enableIn)
    samplerEn |-> &latchEn);

endmodule

bind ro_array_ctrl roac_checker #(.NUM_CELLS(NUM_CELLS), .TOTAL(TOTAL)) u_chk (
  .clk(clk), .enableIn(enableIn), .cellOut(cellOut), .latchEn(latchEn),
  .pathSel(pathSel), .randBit(randBit), .samplerEn(samplerEn)
);

// File: tb/tb_ro_array_ctrl.sv
module tb_ro_array_ctrl;
  localparam int N     = 3;
  localparam int TOTAL = 8 + 12 + 16;   // R6: segments 8, 12, 16

  logic clk = 1'b0;
  logic enableIn = 1'b0;
  logic [N-1:0] cellOut = '0;
  logic [TOTAL-1:0] latchEn;
  logic [N-1:0] pathSel;
  logic randBit, samplerEn;

  int nChecks = 0, nFails = 0;
  logic mFirst = 1'b0, mSecond = 1'b0;
  int mFill = 0;
  bit done = 1'b0;

  ro_array_ctrl dut (
    .clk(clk), .enableIn(enableIn), .cellOut(cellOut), .latchEn(latchEn),
    .pathSel(pathSel), .randBit(randBit), .samplerEn(samplerEn)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] expSel(logic [N-1:0] c, logic dir);
    logic [N-1:0] s;
    for (int i = 0; i < N; i++)
      s[i] = dir ? c[(i+1) % N] : c[(i+N-1) % N];   // R3 / R4
    return s;
  endfunction

  function automatic logic [TOTAL-1:0] expFill(int k);
    logic [TOTAL-1:0] v;
    for (int b = 0; b < TOTAL; b++) v[b] = (b < k);
    return v;
  endfunction

  // drive inputs at negedge, check comb select, clock, check registered outputs
  task automatic step(logic en, logic [N-1:0] c);
    enableIn = en;
    cellOut  = c;
    #1;
    chk(mFirst ? "R4" : "R3", 64'(pathSel), 64'(expSel(c, mFirst)));
    @(posedge clk);
    if (!en) begin
      mFirst = 1'b0; mSecond = 1'b0; mFill = 0;
    end else begin
      mSecond = mFirst; mFirst = c[N-1];
      if (mFill < TOTAL) mFill++;
    end
    @(negedge clk);
    chk(en ? "R2" : "R1", 64'(randBit), 64'(mSecond));
    chk(en ? "R5" : "R1", 64'(latchEn), 64'(expFill(mFill)));
    chk("R7", 64'(samplerEn), 64'(mFill == TOTAL));
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    @(negedge clk);
    // R1: disabled with random entropy
    for (int k = 0; k < 6; k++) step(1'b0, N'($urandom));
    // R5/R6/R7: full fill with random entropy, both coupling directions
    for (int k = 0; k < 45; k++) step(1'b1, N'($urandom));
    // R6: cell 0 segment is bits 0..7, cell 1 starts at bit 8
    for (int k = 0; k < 3; k++) step(1'b0, '0);
    for (int k = 0; k < 8; k++) step(1'b1, N'($urandom));
    chk("R6", 64'(latchEn[8]), 64'd0);
    chk("R6", 64'(latchEn[7]), 64'd1);
    // R8: abort mid-fill and restart, last cell high so first random bit would be 1 if not cleared
    step(1'b1, 3'b111);
    step(1'b0, 3'b111);
    chk("R8", 64'(latchEn), 64'd0);
    step(1'b1, 3'b100);
    chk("R8", 64'(randBit), 64'd0);
    chk("R8", 64'(latchEn), 64'd1);
    // R3/R4 directed wrap patterns
    step(1'b1, 3'b001);
    step(1'b1, 3'b110);
    step(1'b1, 3'b011);
    step(1'b1, 3'b101);
    for (int k = 0; k < 60; k++) step(1'b1, N'($urandom));
    // R2: constant last-cell stream
    for (int k = 0; k < 4; k++) step(1'b1, 3'b100);
    chk("R2", 64'(randBit), 64'd1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule